// File: doc/BRIEF.md
# Segment Descriptor Load Checker

This block validates a request to place a 16-bit selector into one of three classes of segment register (stack, code or data) and produces the cached descriptor image that the register file stores. With protection off, it forms a real-addressing result at once. With the virtual-8086 flag set, it also forms a fixed result at once. In protected mode it reads the 8-byte descriptor from either the global or the local descriptor table as two 32-bit words over a simple read port. It then applies the rules that belong to the target register class.

The result is either a success pulse, with selector, base, limit and attributes held on the outputs, or a fault pulse with a fault class and a 16-bit error code. Requests that arrive while a fetch is in progress are ignored. Gate and task-switch handling belong elsewhere.

Top module: `seg_load_checker`

## Requirements
- R1: Selector bit 2 picks the local table (1) or the global table (0), bits 1:0 are the requested privilege (RPL), and bits 15:3 are the index. The descriptor is read at table base plus index times 8 (low word), then at that address plus 4 (high word). If index times 8 is greater than the selected table limit, the load faults with class GP and the selector as error code, and no read is made.
- R2: When `prot_en` is 1 and `v86` is 1, success follows one cycle after the request, with no read. Base is selector shifted left 4, limit is 0xFFFF, `out_base_only` is 0, and `out_attr` is 0xF2 (writable, non-system, privilege 3, present, 16-bit).
- R3: When `prot_en` is 0, success follows one cycle after the request, with no read. `out_base_only` is 1, base is selector shifted left 4, and limit and attributes are zero.
- R4: A global selector with index 0 faults with class GP and error code 0 for the stack and code classes. For the data class it succeeds with base, limit and attributes zero. Neither case makes a read.
- R5: Stack class (`req_kind`=2) faults GP with the selector as code if the descriptor is a system descriptor, is executable, is not writable, or has an RPL different from either the current privilege or the descriptor privilege (DPL).
- R6: A stack-class descriptor that passes R5 but is not present faults with class STACK (1) and the selector as code.
- R7: Code class (`req_kind`=1) checks in this order: a system descriptor gives GP, a non-present descriptor gives NOT-PRESENT (2), and a non-executable descriptor gives GP. All use the selector as code.
- R8: For a code segment that passes R7, a conforming segment faults GP when DPL is greater than the current privilege, and a non-conforming segment faults GP when RPL is less than the current privilege.
- R9: Data class (`req_kind` 0 or 3) faults GP if the descriptor is a system descriptor, or if RPL or the current privilege is greater than DPL. Otherwise a non-present descriptor gives NOT-PRESENT. Privilege is checked before presence.
- R10: The descriptor high word holds base[23:16] in bits 7:0, type in 11:8 (accessed, writable/readable, direction/conforming, executable from bit 8 up), non-system in 12, DPL in 14:13, present in 15, limit[19:16] in 19:16, default size in 22, granularity in 23, and base[31:24] in 31:24. The low word holds limit[15:0] in 15:0 and base[15:0] in 31:16. On success the base is assembled from these fields. The limit is the 20-bit field, or, with granularity set, the field shifted left 12 with the low 12 bits all ones.
- R11: On protected-mode success, `out_attr` packs accessed[0], writable[1], direction/conforming[2], executable[3], non-system[4], DPL[6:5], present[7] and default size[8], and `out_sel` is the requested selector.
- R12: `mem_rd_req` stays high with a stable address until `mem_rd_valid`. Exactly one of `done` or `fault` pulses for one cycle per accepted request, after which `busy` is low. Requests that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load request, accepted when idle |
| req_kind | input | 2 | Target class: 0 data, 1 code, 2 stack, 3 data |
| req_sel | input | 16 | Selector to load |
| req_cpl | input | 2 | Current privilege level |
| prot_en | input | 1 | Protected addressing enabled |
| v86 | input | 1 | Virtual-8086 flag |
| gtbl_base | input | 32 | Global table base address |
| gtbl_lim | input | 16 | Global table limit in bytes |
| ltbl_base | input | 32 | Local table base address |
| ltbl_lim | input | 16 | Local table limit in bytes |
| mem_rd_req | output | 1 | Read request, held until answered |
| mem_rd_addr | output | 32 | Read address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle success pulse |
| fault | output | 1 | One-cycle fault pulse |
| fault_kind | output | 2 | 0 GP, 1 STACK, 2 NOT-PRESENT |
| fault_code | output | 16 | Error code of the fault |
| out_sel | output | 16 | Loaded selector |
| out_base | output | 32 | Cached base |
| out_limit | output | 32 | Cached limit |
| out_attr | output | 9 | Cached attributes |
| out_base_only | output | 1 | Only selector and base are to be updated |

## Verification
A set of global descriptors, each differing from a legal one in a single field (system bit, executable, writable, present, conforming, DPL), is loaded into each register class under several privilege pairs. This shows that each rule fires for the right class and that the order of the rules sets the fault class when two rules are broken together. Table-limit edges on both tables, null selectors in every class, and the real and virtual-8086 paths separate the cases that skip the fetch from those that make it. A granular descriptor with scattered base bits tests field assembly. A varied memory latency, with a second request pushed in during a fetch, tests the read handshake and request blocking.

// File: rtl/seg_load_checker.sv
module seg_load_checker #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [15:0]       req_sel,
  input  logic [1:0]        req_cpl,
  input  logic              prot_en,
  input  logic              v86,
  input  logic [ADDR_W-1:0] gtbl_base,
  input  logic [15:0]       gtbl_lim,
  input  logic [ADDR_W-1:0] ltbl_base,
  input  logic [15:0]       ltbl_lim,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [31:0]       mem_rd_data,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_kind,
  output logic [15:0]       fault_code,
  output logic [15:0]       out_sel,
  output logic [31:0]       out_base,
  output logic [31:0]       out_limit,
  output logic [8:0]        out_attr,
  output logic              out_base_only
);

  localparam logic [1:0] K_CODE  = 2'd1;
  localparam logic [1:0] K_STACK = 2'd2;
  localparam logic [1:0] F_GP    = 2'd0;
  localparam logic [1:0] F_STK   = 2'd1;
  localparam logic [1:0] F_NP    = 2'd2;
  localparam logic [8:0] V86_ATTR = 9'h0F2;

  typedef enum logic [1:0] {S_IDLE, S_RD0, S_RD1} st_t;

  st_t              st;
  logic [15:0]      sel_q;
  logic [1:0]       kind_q, cpl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]      lo_q;

  // request decode
  logic [15:0]       off;
  logic [15:0]       tlim;
  logic [ADDR_W-1:0] tbase;
  logic              in_range, is_null;

  assign off      = {req_sel[15:3], 3'b000};
  assign tlim     = req_sel[2] ? ltbl_lim : gtbl_lim;
  assign tbase    = req_sel[2] ? ltbl_base : gtbl_base;
  assign in_range = off <= tlim;
  assign is_null  = !req_sel[2] && (req_sel[15:3] == 13'd0);

  // descriptor fields (high word on the read port, low word captured)
  logic [31:0] hi;
  logic        d_ac, d_rw, d_dc, d_ex, d_s, d_p, d_db, d_g;
  logic [1:0]  d_dpl, rpl;
  logic [19:0] d_lim;
  logic [31:0] d_base, d_limit;
  logic        unused_bits;

  assign hi      = mem_rd_data;
  assign d_ac    = hi[8];
  assign d_rw    = hi[9];
  assign d_dc    = hi[10];
  assign d_ex    = hi[11];
  assign d_s     = hi[12];
  assign d_dpl   = hi[14:13];
  assign d_p     = hi[15];
  assign d_db    = hi[22];
  assign d_g     = hi[23];
  assign d_lim   = {hi[19:16], lo_q[15:0]};
  assign d_base  = {hi[31:24], hi[7:0], lo_q[31:16]};
  assign d_limit = d_g ? {d_lim, 12'hFFF} : {12'd0, d_lim};
  assign rpl     = sel_q[1:0];
  assign unused_bits = ^hi[21:20];

  logic       chk_fault;
  logic [1:0] chk_kind;

  always_comb begin
    chk_fault = 1'b0;
    chk_kind  = F_GP;
    if (kind_q == K_STACK) begin
      if (!d_s || d_ex || !d_rw || rpl != cpl_q || rpl != d_dpl) chk_fault = 1'b1;
      else if (!d_p) begin chk_fault = 1'b1; chk_kind = F_STK; end
    end else if (kind_q == K_CODE) begin
      if (!d_s) chk_fault = 1'b1;
      else if (!d_p) begin chk_fault = 1'b1; chk_kind = F_NP; end
      else if (!d_ex) chk_fault = 1'b1;
      else if (d_dc ? (d_dpl > cpl_q) : (rpl < cpl_q)) chk_fault = 1'b1;
    end else begin
      if (!d_s || rpl > d_dpl || cpl_q > d_dpl) chk_fault = 1'b1;
      else if (!d_p) begin chk_fault = 1'b1; chk_kind = F_NP; end
    end
  end

  assign busy        = st != S_IDLE;
  assign mem_rd_req  = busy;
  assign mem_rd_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sel_q <= '0; kind_q <= '0; cpl_q <= '0; addr_q <= '0; lo_q <= '0;
      done <= 1'b0; fault <= 1'b0; fault_kind <= F_GP; fault_code <= '0;
      out_sel <= '0; out_base <= '0; out_limit <= '0; out_attr <= '0;
      out_base_only <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          sel_q  <= req_sel;
          kind_q <= req_kind;
          cpl_q  <= req_cpl;
          if (!prot_en) begin
            done <= 1'b1; out_sel <= req_sel; out_base <= {12'd0, req_sel, 4'd0};
            out_limit <= '0; out_attr <= '0; out_base_only <= 1'b1;
          end else if (v86) begin
            done <= 1'b1; out_sel <= req_sel; out_base <= {12'd0, req_sel, 4'd0};
            out_limit <= 32'h0000_FFFF; out_attr <= V86_ATTR; out_base_only <= 1'b0;
          end else if (!in_range) begin
            fault <= 1'b1; fault_kind <= F_GP; fault_code <= req_sel;
          end else if (is_null) begin
            if (req_kind == K_STACK || req_kind == K_CODE) begin
              fault <= 1'b1; fault_kind <= F_GP; fault_code <= '0;
            end else begin
              done <= 1'b1; out_sel <= req_sel; out_base <= '0;
              out_limit <= '0; out_attr <= '0; out_base_only <= 1'b0;
            end
          end else begin
            addr_q <= tbase + {{(ADDR_W-16){1'b0}}, off};
            st     <= S_RD0;
          end
        end
        S_RD0: if (mem_rd_valid) begin
          lo_q   <= mem_rd_data;
          addr_q <= addr_q + ADDR_W'(4);
          st     <= S_RD1;
        end
        S_RD1: if (mem_rd_valid) begin
          st <= S_IDLE;
          if (chk_fault) begin
            fault <= 1'b1; fault_kind <= chk_kind; fault_code <= sel_q;
          end else begin
            done <= 1'b1; out_sel <= sel_q; out_base <= d_base; out_limit <= d_limit;
            out_attr <= {d_db, d_p, d_dpl, d_s, d_ex, d_dc, d_rw, d_ac};
            out_base_only <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));
  a_r12_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> (!busy && !mem_rd_req));
  a_r12_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));
  a_r1_second_word: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_rd_valid && st == S_RD0) |=>
      (mem_rd_req && mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(4)));
  a_r6_stack_only: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && fault_kind == F_STK) |-> (kind_q == K_STACK));

endmodule

// File: tb/seg_load_checker_tb_top.sv
module seg_load_checker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [15:0] req_sel = '0;
  logic [1:0] req_cpl = '0;
  logic prot_en = 1'b1, v86 = 1'b0;
  logic [31:0] gtbl_base = 32'h0001_0000, ltbl_base = 32'h0002_0000;
  logic [15:0] gtbl_lim = 16'h00FF, ltbl_lim = 16'h003F;
  logic mem_rd_req, mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_addr, mem_rd_data = '0;
  logic busy, done, fault, out_base_only;
  logic [1:0] fault_kind;
  logic [15:0] fault_code, out_sel;
  logic [31:0] out_base, out_limit;
  logic [8:0] out_attr;

  seg_load_checker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_sel(req_sel), .req_cpl(req_cpl), .prot_en(prot_en), .v86(v86),
    .gtbl_base(gtbl_base), .gtbl_lim(gtbl_lim), .ltbl_base(ltbl_base),
    .ltbl_lim(ltbl_lim), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .busy(busy),
    .done(done), .fault(fault), .fault_kind(fault_kind), .fault_code(fault_code),
    .out_sel(out_sel), .out_base(out_base), .out_limit(out_limit),
    .out_attr(out_attr), .out_base_only(out_base_only));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, lat = 0, wcnt = 0;
  logic [31:0] mem [int unsigned];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [63:0] mkd(input logic [31:0] b, input logic [19:0] l,
      input logic [3:0] ty, input bit s, input logic [1:0] dpl, input bit p,
      input bit db, input bit g);
    logic [31:0] lo, hi;
    lo = {b[15:0], l[15:0]};
    hi = {b[31:24], g, db, 2'b00, l[19:16], p, dpl, s, ty, b[23:16]};
    return {hi, lo};
  endfunction

  task automatic put(input logic [31:0] a, input logic [63:0] d);
    mem[a] = d[31:0];
    mem[a + 4] = d[63:32];
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory responder
  always @(negedge clk) begin
    if (mem_rd_valid) mem_rd_valid <= 1'b0;
    else if (mem_rd_req) begin
      if (wcnt >= lat) begin
        mem_rd_valid <= 1'b1; mem_rd_data <= rd(mem_rd_addr); wcnt <= 0;
      end else wcnt <= wcnt + 1;
    end else wcnt <= 0;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // behavioural reference
  task automatic model(input logic [1:0] kind, input logic [15:0] sel, input bit prot,
      input bit v, input logic [1:0] cpl, output bit ok, output logic [1:0] fk,
      output logic [15:0] fc, output logic [31:0] eb, output logic [31:0] el,
      output logic [8:0] ea, output bit bo, output int nrd, output logic [31:0] eaddr);
    logic [31:0] lo, hi, tb;
    logic [15:0] tl, o;
    logic [1:0] rp, dpl;
    logic [19:0] l20;
    ok = 0; fk = 0; fc = 0; eb = 0; el = 0; ea = 0; bo = 0; nrd = 0; eaddr = 0;
    if (!prot) begin ok = 1; bo = 1; eb = {12'd0, sel, 4'd0}; end
    else if (v) begin ok = 1; eb = {12'd0, sel, 4'd0}; el = 32'hFFFF; ea = 9'h0F2; end
    else begin
      tb = sel[2] ? ltbl_base : gtbl_base;
      tl = sel[2] ? ltbl_lim : gtbl_lim;
      o = sel & 16'hFFF8;
      if (o > tl) begin fk = 0; fc = sel; end
      else if (!sel[2] && sel[15:3] == 0) begin
        if (kind == 1 || kind == 2) fc = 0; else ok = 1;
      end else begin
        nrd = 2; eaddr = tb + o;
        lo = rd(eaddr); hi = rd(eaddr + 4);
        rp = sel[1:0]; dpl = hi[14:13]; ok = 1; fc = sel;
        if (kind == 2) begin
          if (!hi[12] || hi[11] || !hi[9] || rp != cpl || rp != dpl) begin ok = 0; fk = 0; end
          else if (!hi[15]) begin ok = 0; fk = 1; end
        end else if (kind == 1) begin
          if (!hi[12]) begin ok = 0; fk = 0; end
          else if (!hi[15]) begin ok = 0; fk = 2; end
          else if (!hi[11]) begin ok = 0; fk = 0; end
          else if (hi[10] ? (dpl > cpl) : (rp < cpl)) begin ok = 0; fk = 0; end
        end else begin
          if (!hi[12] || rp > dpl || cpl > dpl) begin ok = 0; fk = 0; end
          else if (!hi[15]) begin ok = 0; fk = 2; end
        end
        if (ok) begin
          eb = {hi[31:24], hi[7:0], lo[31:16]};
          l20 = {hi[19:16], lo[15:0]};
          el = hi[23] ? {l20, 12'hFFF} : {12'd0, l20};
          ea = {hi[22], hi[15], hi[14:13], hi[12], hi[11], hi[10], hi[9], hi[8]};
        end
      end
    end
  endtask

  task automatic run(input string req, input logic [1:0] kind, input logic [15:0] sel,
                     input bit prot, input bit v, input logic [1:0] cpl, input bit poke);
    bit ok, bo; logic [1:0] fk; logic [15:0] fc; logic [31:0] eb, el, ea_w, eaddr;
    logic [8:0] ea; int nrd, reads, cycles;
    model(kind, sel, prot, v, cpl, ok, fk, fc, eb, el, ea, bo, nrd, eaddr);
    ea_w = {23'd0, ea};
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_sel = sel; prot_en = prot; v86 = v; req_cpl = cpl;
    @(negedge clk); #1;
    req_valid = 0;
    reads = 0; cycles = 0;
    while (!(done || fault)) begin
      if (mem_rd_req && mem_rd_valid) begin
        chk(mem_rd_addr == eaddr + 4 * reads, "R1", "read address", mem_rd_addr, eaddr + 4 * reads);
        reads++;
      end
      @(negedge clk); #1;
      cycles++;
      if (poke && cycles == 1) begin req_valid = 1; req_sel = 16'h0040; req_kind = 2'd0; end
      if (poke && cycles == 2) req_valid = 0;
      if (cycles > 60) begin
        chk(0, req, "timeout", cycles, 60);
        return;
      end
    end
    chk(reads == nrd, req, "read count", reads, nrd);
    if (nrd == 0) chk(cycles == 0, req, "latency", cycles, 0);
    chk({done, fault, (fault ? fault_kind : 2'b0)} == {ok, !ok, (ok ? 2'b0 : fk)}, req,
        "outcome {done,fault,kind}", {done, fault, fault_kind}, {ok, !ok, fk});
    if (ok) begin
      chk(out_sel == sel, req, "selector", out_sel, sel);
      chk(out_base == eb, req, "base", out_base, eb);
      chk(out_limit == el, req, "limit", out_limit, el);
      chk({23'd0, out_attr} == ea_w, req, "attributes", out_attr, ea);
      chk(out_base_only == bo, req, "base-only flag", out_base_only, bo);
    end else chk(fault_code == fc, req, "error code", fault_code, fc);
    @(negedge clk); #1;
    chk(!done && !fault && !busy, "R12", "single pulse then idle", {done, fault, busy}, 0);
  endtask

  initial begin
    put(32'h0001_0008, mkd(32'h1234_5678, 20'hABCDE, 4'b0011, 1, 0, 1, 1, 1));
    put(32'h0001_0010, mkd(32'h0000_0000, 20'hFFFFF, 4'b1010, 1, 0, 1, 1, 1));
    put(32'h0001_0018, mkd(32'h0010_0000, 20'h0FFFF, 4'b1110, 1, 3, 1, 0, 0));
    put(32'h0001_0020, mkd(32'h0020_0000, 20'h00FFF, 4'b1110, 1, 0, 1, 1, 0));
    put(32'h0001_0028, mkd(32'h0030_0000, 20'h00100, 4'b0000, 1, 0, 1, 0, 0));
    put(32'h0001_0030, mkd(32'h0040_0000, 20'h00100, 4'b1010, 1, 0, 0, 0, 0));
    put(32'h0001_0038, mkd(32'h0050_0000, 20'h00100, 4'b0010, 1, 0, 0, 0, 0));
    put(32'h0001_0040, mkd(32'h0060_0000, 20'h00100, 4'b0010, 0, 0, 1, 0, 0));
    put(32'h0001_0048, mkd(32'hC0DE_0000, 20'h7FFFF, 4'b0010, 1, 3, 1, 1, 1));
    put(32'h0002_0008, mkd(32'h00AB_C000, 20'h00FFF, 4'b0010, 1, 3, 1, 0, 0));

    #3;
    chk(!done && !fault && !busy && !mem_rd_req, "R12", "reset state",
        {done, fault, busy, mem_rd_req}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;

    run("R3", 2'd0, 16'h1234, 0, 0, 0, 0);
    run("R3", 2'd2, 16'hFFFF, 0, 0, 0, 0);
    run("R2", 2'd0, 16'hB800, 1, 1, 0, 0);
    run("R2", 2'd1, 16'h0008, 1, 1, 3, 0);
    run("R1", 2'd0, 16'h0100, 1, 0, 0, 0);
    run("R1", 2'd0, 16'h0044, 1, 0, 3, 0);
    run("R1", 2'd0, 16'h000F, 1, 0, 3, 0);
    run("R4", 2'd2, 16'h0000, 1, 0, 0, 0);
    run("R4", 2'd1, 16'h0003, 1, 0, 3, 0);
    run("R4", 2'd0, 16'h0003, 1, 0, 3, 0);
    run("R10", 2'd0, 16'h0008, 1, 0, 0, 0);
    lat = 2;
    run("R11", 2'd3, 16'h004B, 1, 0, 2, 0);
    run("R5", 2'd2, 16'h0008, 1, 0, 0, 0);
    run("R5", 2'd2, 16'h0028, 1, 0, 0, 0);
    run("R5", 2'd2, 16'h0010, 1, 0, 0, 0);
    run("R5", 2'd2, 16'h004B, 1, 0, 0, 0);
    run("R5", 2'd2, 16'h004B, 1, 0, 3, 0);
    run("R5", 2'd2, 16'h0040, 1, 0, 0, 0);
    run("R6", 2'd2, 16'h0038, 1, 0, 0, 0);
    lat = 1;
    run("R7", 2'd1, 16'h0008, 1, 0, 0, 0);
    run("R7", 2'd1, 16'h0038, 1, 0, 0, 0);
    run("R7", 2'd1, 16'h0030, 1, 0, 0, 0);
    run("R7", 2'd1, 16'h0040, 1, 0, 0, 0);
    run("R8", 2'd1, 16'h0018, 1, 0, 0, 0);
    run("R8", 2'd1, 16'h0020, 1, 0, 3, 0);
    run("R8", 2'd1, 16'h0010, 1, 0, 3, 0);
    run("R8", 2'd1, 16'h0013, 1, 0, 3, 0);
    lat = 0;
    run("R9", 2'd0, 16'h0040, 1, 0, 0, 0);
    run("R9", 2'd0, 16'h000B, 1, 0, 0, 0);
    run("R9", 2'd0, 16'h0008, 1, 0, 3, 0);
    run("R9", 2'd0, 16'h0038, 1, 0, 0, 0);
    run("R9", 2'd0, 16'h003B, 1, 0, 0, 0);
    run("R9", 2'd3, 16'h000F, 1, 0, 3, 0);
    lat = 3;
    run("R12", 2'd0, 16'h0008, 1, 0, 0, 1);
    run("R12", 2'd2, 16'h0008, 1, 0, 0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule